// File: doc/BRIEF.md
# Vector Line Stepping Engine

This block is the stepping core of a graphics terminal's line drawer. The host loads four byte-wide parameters into a small register file: how long the line is along its dominant axis, how far it travels along the other axis, which way it heads, and the write-operation byte passed on to the pixel combiner. A separate strobe loads the reload value for the pattern multiplier. An execute strobe then arms the engine and captures a 2-bit drawing mode. Arming alone does not start the line. Stepping waits for the next display sync pulse.

While drawing, the engine keeps the current X/Y position, an error accumulator that decides when the secondary axis moves, and a count of pixels still to go. It offers one pixel-write request per step on a valid/ready port. The request carries the position, the current walking pattern mask, the latched mode and the write-operation byte. The request stays up with a frozen payload until the consumer raises ready, so the consumer can apply back-pressure for as long as it needs. The position, the error and the pattern advance only on a cycle where valid and ready are both high. An active-low busy status tells the host when it may load the next vector.

Top module: `vec_stepper`

## Requirements
- R1: A write with `reg_wr_en` stores `reg_wr_data` into the entry chosen by `reg_wr_addr`. Entry 0 is the major length, 1 the minor length, 2 the direction (only bits 2:0 are used) and 3 the write-op byte, and entry 3 always drives `px_wops`. `pmul_wr_en` stores `reg_wr_data` as the pattern-multiplier reload value.
- R2: An execute accepted while idle latches `exec_mode` onto `px_mode` by the next cycle. An execute seen while `go_n` is low is ignored, and `px_mode` and the vector in progress are left unchanged.
- R3: An accepted execute loads the pixel down-counter from the major length, loads the pattern counter from its reload value, sets the pattern mask to 0x80 and clears the error accumulator. The vector then issues exactly major-length pixel requests, and the first one is at the position held before execute.
- R4: `go_n` goes low on the clock edge that accepts execute. `px_valid` first rises the cycle after a later `sync_pulse`. A sync pulse in the same cycle as the execute does not start drawing.
- R5: After each accepted pixel the position moves one unit along the major axis: code 0 +X, 1 +Y, 2 +Y, 3 −X, 4 −X, 5 −Y, 6 −Y, 7 +X. When a minor step is due, it moves the other axis: code 0 +Y, 1 +X, 2 −X, 3 +Y, 4 −Y, 5 −X, 6 +X, 7 −Y. Coordinates wrap modulo 2^12.
- R6: On each step the accumulator adds the minor length. If the sum is at least the major length, a minor-axis step is taken and the major length is subtracted from the sum. A line of major M and minor N therefore ends with exactly N minor steps when N ≤ M.
- R7: On each accepted pixel, if the pattern counter is zero the mask rotates right by one bit (bit 0 wraps to bit 7) and the counter reloads. Otherwise the counter decrements. With reload P the mask moves once per P+1 pixels.
- R8: `go_n` returns high on the edge that accepts the final pixel. With a major length of 0, the starting sync pulse returns `go_n` high with no request and no movement.
- R9: While `px_valid` is high and `px_ready` is low, `px_valid`, `px_x`, `px_y` and `px_mask` hold their values.
- R10: Reset forces `go_n` high, `px_valid` low, X and Y to 0, the mask to 0x80, `px_mode` to 0, and all four registers (so `px_wops`) to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr_en | input | 1 | Register file write strobe |
| reg_wr_addr | input | 2 | Register file entry select |
| reg_wr_data | input | 8 | Write data for registers and reload value |
| pmul_wr_en | input | 1 | Pattern-multiplier reload write strobe |
| exec_stb | input | 1 | Execute strobe |
| exec_mode | input | 2 | Drawing mode, taken from the execute offset's low bits |
| sync_pulse | input | 1 | Display sync pulse that starts an armed vector |
| px_valid | output | 1 | Pixel-write request valid |
| px_ready | input | 1 | Pixel-write request accepted |
| px_x | output | 12 | Current X position |
| px_y | output | 12 | Current Y position |
| px_mask | output | 8 | Current walking pattern mask |
| px_mode | output | 2 | Latched drawing mode |
| px_wops | output | 8 | Write-operation register |
| go_n | output | 1 | Low while a vector is armed or drawing |

## Verification
Two pairs of events can land in the same cycle. The first is an execute with a sync pulse. The bench drives both strobes on one edge and checks that `px_valid` stays low through several further cycles and rises only after a separate later sync. The second is a stall with a new execute. While the engine is busy and stalled by a low `px_ready`, the bench issues an execute with a different mode. It then judges that the payload stays frozen, that `px_mode` keeps its old value and that the pixel count of the running vector does not change.

// File: rtl/vec_pkg.sv
package vec_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } st_e;

  localparam int IDX_MAJ  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_DIR  = 2;
  localparam int IDX_WOPS = 3;

  typedef struct packed {
    logic maj_y;    // major axis is Y
    logic maj_neg;  // major axis steps down
    logic min_neg;  // minor axis steps down
  } dir_t;

  function automatic dir_t decode_dir(input logic [2:0] code);
    dir_t d;
    case (code)
      3'd0:    d = '{maj_y: 1'b0, maj_neg: 1'b0, min_neg: 1'b0};
      3'd1:    d = '{maj_y: 1'b1, maj_neg: 1'b0, min_neg: 1'b0};
      3'd2:    d = '{maj_y: 1'b1, maj_neg: 1'b0, min_neg: 1'b1};
      3'd3:    d = '{maj_y: 1'b0, maj_neg: 1'b1, min_neg: 1'b0};
      3'd4:    d = '{maj_y: 1'b0, maj_neg: 1'b1, min_neg: 1'b1};
      3'd5:    d = '{maj_y: 1'b1, maj_neg: 1'b1, min_neg: 1'b1};
      3'd6:    d = '{maj_y: 1'b1, maj_neg: 1'b1, min_neg: 1'b0};
      default: d = '{maj_y: 1'b0, maj_neg: 1'b0, min_neg: 1'b1};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/vec_regfile.sv
module vec_regfile #(
  parameter  int DW   = 8,
  parameter  int NREG = 4,
  localparam int AW   = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [DW-1:0]             wr_data,
  input  logic                      pmul_wr,
  output logic [NREG-1:0][DW-1:0]   regs_o,
  output logic [DW-1:0]             pmul_o
);

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    logic [DW-1:0] ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   ent_q <= '0;
      else if (wr_en && (wr_addr == AW'(i)))        ent_q <= wr_data;
    end
    assign regs_o[i] = ent_q;
  end

  logic [DW-1:0] pmul_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pmul_q <= '0;
    else if (pmul_wr)  pmul_q <= wr_data;
  end
  assign pmul_o = pmul_q;

  // R1: an entry not addressed by a write keeps its value
  a_r1_untouched_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != AW'(0)) |=> $stable(regs_o[0]));

endmodule

// File: rtl/vec_dda.sv
module vec_dda
  import vec_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [DW-1:0] major,
  input  logic [DW-1:0] minor,
  input  logic [2:0]    dcode,
  output logic [CW-1:0] x_o,
  output logic [CW-1:0] y_o
);

  logic [DW-1:0] err_q;
  logic [CW-1:0] x_q, y_q;
  dir_t          dsel;
  logic [DW:0]   sum, nxt;
  logic          min_step;
  logic [CW-1:0] maj_delta, min_delta;
  logic          unused_nxt_msb;

  always_comb begin
    dsel      = decode_dir(dcode);
    sum       = {1'b0, err_q} + {1'b0, minor};
    min_step  = (sum >= {1'b0, major});
    nxt       = min_step ? (sum - {1'b0, major}) : sum;
    maj_delta = dsel.maj_neg ? '1 : CW'(1);
    min_delta = !min_step ? '0 : (dsel.min_neg ? '1 : CW'(1));
  end
  assign unused_nxt_msb = nxt[DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
      x_q   <= '0;
      y_q   <= '0;
    end else if (load) begin
      err_q <= '0;
    end else if (step) begin
      err_q <= nxt[DW-1:0];
      x_q   <= x_q + (dsel.maj_y ? min_delta : maj_delta);
      y_q   <= y_q + (dsel.maj_y ? maj_delta : min_delta);
    end
  end

  assign x_o = x_q;
  assign y_o = y_q;

  // R5: each accepted pixel moves X by at most one unit
  a_r5_unit_x: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ((CW'(x_q - $past(x_q)) <= CW'(1)) || (CW'(x_q - $past(x_q)) == '1)));
  // R5: each accepted pixel moves Y by at most one unit
  a_r5_unit_y: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ((CW'(y_q - $past(y_q)) <= CW'(1)) || (CW'(y_q - $past(y_q)) == '1)));
  // R9: no movement without an accepted pixel
  a_r9_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(x_q) && $stable(y_q)));

endmodule

// File: rtl/vec_pattern.sv
module vec_pattern #(
  parameter  int DW = 8,
  parameter  int MW = 8,
  localparam logic [MW-1:0] MASK_INIT = MW'(1) << (MW-1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [DW-1:0] reload,
  output logic [MW-1:0] mask_o
);

  logic [MW-1:0] mask_q;
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_INIT;
      cnt_q  <= '0;
    end else if (load) begin
      mask_q <= MASK_INIT;
      cnt_q  <= reload;
    end else if (step) begin
      if (cnt_q == '0) begin
        mask_q <= {mask_q[0], mask_q[MW-1:1]};
        cnt_q  <= reload;
      end else begin
        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign mask_o = mask_q;

  // R7: the mask only moves on an accepted pixel or an execute
  a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(mask_q));
  // R7: while the counter is still running down the mask does not move
  a_r7_no_early_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cnt_q != '0) |=> $stable(mask_q));

endmodule

// File: rtl/vec_stepper.sv
module vec_stepper
  import vec_pkg::*;
#(
  parameter  int DW   = 8,
  parameter  int CW   = 12,
  parameter  int MW   = 8,
  parameter  int NREG = 4,
  localparam int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic [AW-1:0] reg_wr_addr,
  input  logic [DW-1:0] reg_wr_data,
  input  logic          pmul_wr_en,
  input  logic          exec_stb,
  input  logic [1:0]    exec_mode,
  input  logic          sync_pulse,
  output logic          px_valid,
  input  logic          px_ready,
  output logic [CW-1:0] px_x,
  output logic [CW-1:0] px_y,
  output logic [MW-1:0] px_mask,
  output logic [1:0]    px_mode,
  output logic [DW-1:0] px_wops,
  output logic          go_n
);

  logic [NREG-1:0][DW-1:0] regs;
  logic [DW-1:0]           pmul_val;
  logic [DW-1:0]           maj, mnr, dirr;
  logic                    unused_dir_hi;

  st_e           st_q;
  logic [DW-1:0] dcnt_q;
  logic [1:0]    mode_q;
  logic          exec_ok, step;

  vec_regfile #(.DW(DW), .NREG(NREG)) i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_addr (reg_wr_addr),
    .wr_data (reg_wr_data),
    .pmul_wr (pmul_wr_en),
    .regs_o  (regs),
    .pmul_o  (pmul_val)
  );

  assign maj           = regs[IDX_MAJ];
  assign mnr           = regs[IDX_MIN];
  assign dirr          = regs[IDX_DIR];
  assign px_wops       = regs[IDX_WOPS];
  assign unused_dir_hi = ^dirr[DW-1:3];

  assign exec_ok  = exec_stb && (st_q == ST_IDLE);
  assign px_valid = (st_q == ST_RUN) && (dcnt_q != '0);
  assign step     = px_valid && px_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dcnt_q <= '0;
      mode_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (exec_ok) begin
          st_q   <= ST_ARMED;
          dcnt_q <= maj;
          mode_q <= exec_mode;
        end
        ST_ARMED: if (sync_pulse) begin
          st_q <= (dcnt_q == '0) ? ST_IDLE : ST_RUN;
        end
        ST_RUN: if (step) begin
          dcnt_q <= dcnt_q - 1'b1;
          if (dcnt_q == DW'(1)) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  vec_dda #(.DW(DW), .CW(CW)) i_dda (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (exec_ok),
    .step  (step),
    .major (maj),
    .minor (mnr),
    .dcode (dirr[2:0]),
    .x_o   (px_x),
    .y_o   (px_y)
  );

  vec_pattern #(.DW(DW), .MW(MW)) i_pat (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (exec_ok),
    .step   (step),
    .reload (pmul_val),
    .mask_o (px_mask)
  );

  assign px_mode = mode_q;
  assign go_n    = (st_q == ST_IDLE);

  // R4: a request only begins the cycle after a sync pulse
  a_r4_start_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(px_valid) |-> $past(sync_pulse));
  // R4: sync coinciding with execute does not start drawing
  a_r4_sync_with_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_ok && sync_pulse) |=> !px_valid);
  // R9: a stalled request keeps its payload
  a_r9_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && !px_ready) |=> (px_valid && $stable(px_x) && $stable(px_y) && $stable(px_mask)));
  // R8: the final accepted pixel ends the vector
  a_r8_done: assert property (@(posedge clk) disable iff (!rst_n)
    (step && dcnt_q == DW'(1)) |=> go_n);
  // R2: the mode cannot change while busy
  a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !go_n |=> $stable(px_mode));

endmodule

// File: tb/test_vec_stepper.sv
module test_vec_stepper;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_wr_addr = '0;
  logic [7:0]  reg_wr_data = '0;
  logic        pmul_wr_en = 1'b0;
  logic        exec_stb = 1'b0;
  logic [1:0]  exec_mode = '0;
  logic        sync_pulse = 1'b0;
  logic        px_valid;
  logic        px_ready = 1'b1;
  logic [11:0] px_x, px_y;
  logic [7:0]  px_mask;
  logic [1:0]  px_mode;
  logic [7:0]  px_wops;
  logic        go_n;

  always #4 clk = ~clk;  // 125 MHz

  vec_stepper i_vec_stepper (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .pmul_wr_en(pmul_wr_en), .exec_stb(exec_stb),
    .exec_mode(exec_mode), .sync_pulse(sync_pulse), .px_valid(px_valid),
    .px_ready(px_ready), .px_x(px_x), .px_y(px_y), .px_mask(px_mask),
    .px_mode(px_mode), .px_wops(px_wops), .go_n(go_n)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic [7:0]  maj;
    logic [7:0]  mnr;
    logic [7:0]  dir;
    logic [7:0]  pmul;
    logic [1:0]  mode;
    logic [11:0] ex_x;
    logic [11:0] ex_y;
    logic [7:0]  ex_mask;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t TBL [NV] = '{
    '{maj: 8'd5, mnr: 8'd0, dir: 8'd0, pmul: 8'd0, mode: 2'd0, ex_x: 12'd5,    ex_y: 12'd0,    ex_mask: 8'h04},
    '{maj: 8'd4, mnr: 8'd4, dir: 8'd1, pmul: 8'd1, mode: 2'd1, ex_x: 12'd4,    ex_y: 12'd4,    ex_mask: 8'h20},
    '{maj: 8'd6, mnr: 8'd3, dir: 8'd3, pmul: 8'd2, mode: 2'd2, ex_x: 12'd4090, ex_y: 12'd3,    ex_mask: 8'h20},
    '{maj: 8'd3, mnr: 8'd1, dir: 8'd4, pmul: 8'd0, mode: 2'd3, ex_x: 12'd4093, ex_y: 12'd4095, ex_mask: 8'h10},
    '{maj: 8'd2, mnr: 8'd0, dir: 8'd6, pmul: 8'd7, mode: 2'd0, ex_x: 12'd0,    ex_y: 12'd4094, ex_mask: 8'h80},
    '{maj: 8'd9, mnr: 8'd0, dir: 8'd0, pmul: 8'd0, mode: 2'd1, ex_x: 12'd9,    ex_y: 12'd0,    ex_mask: 8'h40}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic wr_pmul(input logic [7:0] d);
    pmul_wr_en = 1'b1; reg_wr_data = d;
    @(negedge clk);
    pmul_wr_en = 1'b0;
  endtask

  task automatic pulse(input bit ex, input bit sy, input logic [1:0] m);
    exec_stb = ex; sync_pulse = sy; exec_mode = m;
    @(negedge clk);
    exec_stb = 1'b0; sync_pulse = 1'b0;
  endtask

  task automatic run_idle(output int npix, output int fx, output int fy);
    npix = 0; fx = -1; fy = -1;
    for (int k = 0; k < 2000; k++) begin
      if (go_n) break;
      if (px_valid && px_ready) begin
        if (npix == 0) begin fx = px_x; fy = px_y; end
        npix++;
      end
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int np, fx, fy;
    do_reset();

    // R10: reset state
    chk("R10 go_n", go_n, 1);
    chk("R10 px_valid", px_valid, 0);
    chk("R10 px_x", px_x, 0);
    chk("R10 px_y", px_y, 0);
    chk("R10 px_mask", px_mask, 8'h80);
    chk("R10 px_mode", px_mode, 0);
    chk("R10 px_wops", px_wops, 0);

    // R1: write-op entry at offset 3
    wr_reg(2'd3, 8'hA5);
    chk("R1 wops", px_wops, 8'hA5);
    wr_reg(2'd2, 8'h00);
    chk("R1 wops kept", px_wops, 8'hA5);

    // Table walk: R3 R5 R6 R7 R2 R8
    for (int v = 0; v < NV; v++) begin
      do_reset();
      wr_reg(2'd0, TBL[v].maj);
      wr_reg(2'd1, TBL[v].mnr);
      wr_reg(2'd2, TBL[v].dir);
      wr_pmul(TBL[v].pmul);
      pulse(1'b1, 1'b0, TBL[v].mode);
      chk("R4 busy after exec", go_n, 0);
      chk("R2 mode latched", px_mode, TBL[v].mode);
      chk("R3 mask init", px_mask, 8'h80);
      @(negedge clk);
      pulse(1'b0, 1'b1, 2'd0);
      run_idle(np, fx, fy);
      chk("R3 pixel count", np, TBL[v].maj);
      chk("R3 first x", fx, 0);
      chk("R3 first y", fy, 0);
      chk("R5 final x", px_x, TBL[v].ex_x);
      chk("R6 final y", px_y, TBL[v].ex_y);
      chk("R7 final mask", px_mask, TBL[v].ex_mask);
      chk("R8 idle after line", go_n, 1);
    end

    // R4: exec and sync together; R9 stall; R2 exec while busy
    do_reset();
    px_ready = 1'b0;
    wr_reg(2'd0, 8'd3);
    pulse(1'b1, 1'b1, 2'd1);
    chk("R4 go_n low", go_n, 0);
    chk("R4 no start on same sync", px_valid, 0);
    repeat (4) @(negedge clk);
    chk("R4 still waiting", px_valid, 0);
    pulse(1'b0, 1'b1, 2'd0);
    chk("R4 start after sync", px_valid, 1);
    pulse(1'b1, 1'b0, 2'd3);
    @(negedge clk);
    chk("R9 valid held", px_valid, 1);
    chk("R9 x held", px_x, 0);
    chk("R9 mask held", px_mask, 8'h80);
    chk("R2 busy exec ignored", px_mode, 1);
    px_ready = 1'b1;
    run_idle(np, fx, fy);
    chk("R2 count unchanged", np, 3);
    chk("R5 x after stall", px_x, 3);

    // R8: zero major length
    wr_reg(2'd0, 8'd0);
    pulse(1'b1, 1'b0, 2'd2);
    chk("R8 armed", go_n, 0);
    pulse(1'b0, 1'b1, 2'd0);
    chk("R8 zero done", go_n, 1);
    chk("R8 zero no req", px_valid, 0);
    chk("R8 zero no move", px_x, 3);

    // R10: reset mid-vector clears registers
    wr_reg(2'd0, 8'd5);
    wr_reg(2'd3, 8'h3C);
    pulse(1'b1, 1'b0, 2'd2);
    pulse(1'b0, 1'b1, 2'd0);
    @(negedge clk);
    do_reset();
    chk("R10 mid go_n", go_n, 1);
    chk("R10 mid x", px_x, 0);
    chk("R10 mid mode", px_mode, 0);
    chk("R10 mid wops", px_wops, 0);
    chk("R10 mid mask", px_mask, 8'h80);
    pulse(1'b1, 1'b0, 2'd0);
    pulse(1'b0, 1'b1, 2'd0);
    chk("R10 major cleared", go_n, 1);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule